// File: doc/BRIEF.md
# Register-to-DRP Access Bridge

This block gives a host processor indirect access to the dynamic reconfiguration port (DRP) of a clock manager. It does this through a small memory-mapped register window. To start a DRP transaction, the host writes one control word. That word holds the start flag, the direction, the 7-bit DRP address and the 16-bit write data. The host then polls a status word. The status word holds a busy flag and the 16 bits captured from the last DRP read. The bridge pulses DRP enable for exactly one cycle and drives write-enable only for writes. It holds busy until the clock manager answers with its ready pulse.

Two further registers sit in the same window:
- A reset/enable register. One bit releases the general enable and the other enables the clock manager.
- A clock-source select register that picks one of two reference clocks.

The host bus is a plain strobe interface. A write takes effect on the edge where its strobe is sampled. Read data is registered and appears the cycle after the read strobe.

Top module: `drp_reg_bridge`

## Requirements
- R1: After reset, `drp_en` and `drp_we` are low. Reads of offsets 0x40, 0x44 and 0x74 all return 0: busy clear, captured data zero, both enable bits clear, select zero.
- R2: A write to offset 0x40 stores bit 0 on `core_en` and bit 1 on `mgr_en` from the next cycle. A read of 0x40 returns them in bits 1:0 with all other bits zero.
- R3: A write to offset 0x44 stores bit 0 on `clk_sel`. A read of 0x44 returns it in bit 0 with all other bits zero.
- R4: A write to offset 0x70 with bit 29 set while idle starts one DRP transaction. In the next cycle `drp_en` is high for exactly one cycle, with `drp_addr` taken from bits 22:16.
- R5: Bit 28 of that control word selects a read when 1 and a write when 0. For a write, `drp_we` is high together with `drp_en` and `drp_di` carries bits 15:0. For a read, `drp_we` stays low.
- R6: A control write with bit 29 clear starts no transaction and leaves busy clear.
- R7: Status bit 16 (busy) is 1 from the cycle after an accepted control write until the cycle after `drp_rdy` is sampled high.
- R8: For a read, the bridge captures `drp_do` on the ready cycle and returns it in status bits 15:0. A DRP write leaves those bits unchanged.
- R9: A control write that arrives while busy is set is ignored, and this includes the cycle in which `drp_rdy` is high.
- R10: A status read issued in the same cycle as `drp_rdy` returns the state before completion: busy 1 and the old data.
- R11: Read data appears on `bus_rdata` the cycle after `bus_rd_en`. Offset 0x70 and any unmapped offset read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| core_en | output | 1 | General enable / reset release |
| mgr_en | output | 1 | Clock manager enable |
| clk_sel | output | 1 | Reference clock select |
| drp_en | output | 1 | DRP enable, one cycle per transaction |
| drp_we | output | 1 | DRP write enable |
| drp_addr | output | 7 | DRP register address |
| drp_di | output | 16 | DRP write data |
| drp_rdy | input | 1 | DRP ready pulse |
| drp_do | input | 16 | DRP read data |

## Verification
Completion of a DRP transaction can land in the same cycle as host activity in two ways. A status read can coincide with the ready pulse, and so can a fresh control write. The bench counts cycles from the control write and sets its responder latency so that the host strobe lands exactly on the ready cycle. It then judges the outcome from the ports. The coincident status read must still show busy with the old data, and the following read must show the new data. The coincident control write must produce no second enable pulse, and its target register must remain untouched when it is read back afterwards.

// File: rtl/drp_bridge_pkg.sv
`timescale 1ns/1ps
package drp_bridge_pkg;
    localparam int BUS_DATA_W    = 32;
    localparam int OFS_RESET     = 'h40;
    localparam int OFS_SELECT    = 'h44;
    localparam int OFS_CONTROL   = 'h70;
    localparam int OFS_STATUS    = 'h74;
    localparam int CTL_START_BIT = 29;
    localparam int CTL_READ_BIT  = 28;
    localparam int CTL_ADDR_LSB  = 16;
    localparam int STAT_BUSY_BIT = 16;
endpackage

// File: rtl/drp_cfg_regs.sv
`timescale 1ns/1ps
module drp_cfg_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_reset_i,
    input  logic       wr_select_i,
    input  logic [1:0] wdata_i,
    output logic       core_en_o,
    output logic       mgr_en_o,
    output logic       sel_o
);
    typedef struct packed {
        logic core_en;
        logic mgr_en;
        logic sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_reset_i) begin
            cfg_d.core_en = wdata_i[0];
            cfg_d.mgr_en  = wdata_i[1];
        end
        if (wr_select_i) begin
            cfg_d.sel = wdata_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign core_en_o = cfg_q.core_en;
    assign mgr_en_o  = cfg_q.mgr_en;
    assign sel_o     = cfg_q.sel;

    AST_RESET_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_reset_i |=> $stable({core_en_o, mgr_en_o})); // R2
    AST_SELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_select_i |=> $stable(sel_o)); // R3
endmodule

// File: rtl/drp_txn_engine.sv
`timescale 1ns/1ps
module drp_txn_engine #(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          drp_rdy_i,
    input  logic [DW-1:0] drp_do_i,
    output logic          busy_o,
    output logic [DW-1:0] rdat_o,
    output logic          drp_en_o,
    output logic          drp_we_o,
    output logic [AW-1:0] drp_addr_o,
    output logic [DW-1:0] drp_di_o
);
    typedef struct packed {
        logic          busy;
        logic          en;
        logic          we;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] di;
        logic [DW-1:0] rdat;
    } eng_t;

    eng_t st_d, st_q;
    logic accept;
    logic finish;

    always_comb begin
        accept = !st_q.busy && start_i;
        finish = st_q.busy && !st_q.en && drp_rdy_i;
        st_d    = st_q;
        st_d.en = 1'b0;
        st_d.we = 1'b0;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.en   = 1'b1;
            st_d.we   = !rd_i;
            st_d.rd   = rd_i;
            st_d.addr = addr_i;
            st_d.di   = data_i;
        end else if (finish) begin
            st_d.busy = 1'b0;
            if (st_q.rd) begin
                st_d.rdat = drp_do_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o     = st_q.busy;
    assign rdat_o     = st_q.rdat;
    assign drp_en_o   = st_q.en;
    assign drp_we_o   = st_q.we;
    assign drp_addr_o = st_q.addr;
    assign drp_di_o   = st_q.di;

    AST_EN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en_o |=> !drp_en_o); // R4
    AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        drp_we_o |-> drp_en_o); // R5
    AST_EN_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en_o |-> busy_o); // R7
    AST_BUSY_UNTIL_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !drp_rdy_i) |=> busy_o); // R7
    AST_RDY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !drp_en_o && drp_rdy_i) |=> !busy_o); // R7
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !drp_en_o); // R9
    AST_RDAT_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && drp_rdy_i && !drp_en_o && st_q.rd) |=> $stable(rdat_o)); // R8
endmodule

// File: rtl/drp_reg_bridge.sv
`timescale 1ns/1ps
module drp_reg_bridge
    import drp_bridge_pkg::*;
#(
    parameter int BUS_ADDR_W = 8,
    parameter int DRP_ADDR_W = 7,
    parameter int DRP_DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic                  bus_rd_en,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [BUS_DATA_W-1:0] bus_wdata,
    output logic [BUS_DATA_W-1:0] bus_rdata,
    output logic                  core_en,
    output logic                  mgr_en,
    output logic                  clk_sel,
    output logic                  drp_en,
    output logic                  drp_we,
    output logic [DRP_ADDR_W-1:0] drp_addr,
    output logic [DRP_DATA_W-1:0] drp_di,
    input  logic                  drp_rdy,
    input  logic [DRP_DATA_W-1:0] drp_do
);
    localparam int ADDR_TOP = CTL_ADDR_LSB + DRP_ADDR_W;

    logic                  hit_reset, hit_select, hit_control, hit_status;
    logic                  busy;
    logic [DRP_DATA_W-1:0] rdat;
    logic [BUS_DATA_W-1:0] rdata_d, rdata_q;
    logic                  unused_ok;

    always_comb begin
        hit_reset   = (bus_addr == BUS_ADDR_W'(OFS_RESET));
        hit_select  = (bus_addr == BUS_ADDR_W'(OFS_SELECT));
        hit_control = (bus_addr == BUS_ADDR_W'(OFS_CONTROL));
        hit_status  = (bus_addr == BUS_ADDR_W'(OFS_STATUS));
    end

    assign unused_ok = ^{bus_wdata[BUS_DATA_W-1:CTL_START_BIT+1],
                         bus_wdata[CTL_READ_BIT-1:ADDR_TOP]};

    drp_cfg_regs cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_reset_i  (bus_wr_en && hit_reset),
        .wr_select_i (bus_wr_en && hit_select),
        .wdata_i     (bus_wdata[1:0]),
        .core_en_o   (core_en),
        .mgr_en_o    (mgr_en),
        .sel_o       (clk_sel)
    );

    drp_txn_engine #(
        .AW (DRP_ADDR_W),
        .DW (DRP_DATA_W)
    ) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (bus_wr_en && hit_control && bus_wdata[CTL_START_BIT]),
        .rd_i       (bus_wdata[CTL_READ_BIT]),
        .addr_i     (bus_wdata[ADDR_TOP-1:CTL_ADDR_LSB]),
        .data_i     (bus_wdata[DRP_DATA_W-1:0]),
        .drp_rdy_i  (drp_rdy),
        .drp_do_i   (drp_do),
        .busy_o     (busy),
        .rdat_o     (rdat),
        .drp_en_o   (drp_en),
        .drp_we_o   (drp_we),
        .drp_addr_o (drp_addr),
        .drp_di_o   (drp_di)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd_en) begin
            rdata_d = '0;
            if (hit_reset) begin
                rdata_d[1:0] = {mgr_en, core_en};
            end else if (hit_select) begin
                rdata_d[0] = clk_sel;
            end else if (hit_status) begin
                rdata_d[STAT_BUSY_BIT]   = busy;
                rdata_d[DRP_DATA_W-1:0] = rdat;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata)); // R11
    AST_CONTROL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && hit_control) |=> (bus_rdata == '0)); // R11
    AST_STATUS_SHOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && hit_status && busy) |=> bus_rdata[STAT_BUSY_BIT]); // R10
endmodule

// File: tb/drp_reg_bridge_tb.sv
`timescale 1ns/1ps
module drp_reg_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_en, mgr_en, clk_sel;
    logic        drp_en, drp_we;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di;
    logic        drp_rdy = 1'b0;
    logic [15:0] drp_do = '0;

    always #4 clk = ~clk;

    drp_reg_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_en(core_en), .mgr_en(mgr_en), .clk_sel(clk_sel),
        .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
        .drp_rdy(drp_rdy), .drp_do(drp_do)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // responder state
    logic [15:0] mem [128];
    int          lat_cfg = 1;
    int          cnt = 0;
    int          en_count = 0;
    logic [6:0]  rsp_addr = '0;
    logic        rsp_we = 1'b0;
    logic [15:0] rsp_di = '0;

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            drp_rdy = 1'b0;
            if (cnt > 0) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    drp_rdy = 1'b1;
                    drp_do  = mem[rsp_addr];
                end
            end
            if (drp_en) begin
                en_count = en_count + 1;
                rsp_addr = drp_addr;
                rsp_we   = drp_we;
                rsp_di   = drp_di;
                if (drp_we) mem[drp_addr] = drp_di;
                cnt = lat_cfg;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctl(input bit go, input bit rd, input logic [6:0] a, input logic [15:0] d);
        return {2'b00, go, rd, 5'b0, a, d};
    endfunction

    task automatic wait_idle(output logic [31:0] st);
        st = 32'h0001_0000;
        for (int k = 0; k < 60 && st[16]; k++) bus_read(8'h74, st);
    endtask

    // {rd, addr[6:0], latency[7:0], data/expected[15:0]}
    localparam logic [31:0] VEC [8] = '{
        {1'b0, 7'h08, 8'd1, 16'h1234},
        {1'b0, 7'h16, 8'd3, 16'hBEEF},
        {1'b1, 7'h08, 8'd2, 16'h1234},
        {1'b0, 7'h7F, 8'd5, 16'hA5A5},
        {1'b1, 7'h16, 8'd1, 16'hBEEF},
        {1'b1, 7'h7F, 8'd4, 16'hA5A5},
        {1'b0, 7'h00, 8'd2, 16'hFFFF},
        {1'b1, 7'h00, 8'd7, 16'hFFFF}
    };

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [15:0] model_rd;
        int e0;
        model_rd = '0;
        repeat (3) @(negedge clk);
        chk(drp_en == 0 && drp_we == 0, "R1 drp pins in reset", {drp_en, drp_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(8'h40, r); chk(r == 0, "R1 reset reg", r, 0);
        bus_read(8'h44, r); chk(r == 0, "R1 select reg", r, 0);
        bus_read(8'h74, r); chk(r == 0, "R1 status", r, 0);

        bus_write(8'h40, 32'hFFFF_FFFD);
        chk(core_en == 1 && mgr_en == 0, "R2 pins 01", {mgr_en, core_en}, 1);
        bus_read(8'h40, r); chk(r == 32'h1, "R2 readback 01", r, 1);
        bus_write(8'h40, 32'h2);
        bus_read(8'h40, r); chk(r == 32'h2 && mgr_en && !core_en, "R2 readback 10", r, 2);
        bus_write(8'h44, 32'hFFFF_FFFF);
        chk(clk_sel == 1, "R3 pin", clk_sel, 1);
        bus_read(8'h44, r); chk(r == 32'h1, "R3 readback", r, 1);
        bus_write(8'h44, 32'h0);
        bus_read(8'h44, r); chk(r == 0, "R3 cleared", r, 0);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, r); chk(r == 0, "R11 unmapped", r, 0);

        for (int v = 0; v < 8; v++) begin
            logic        rd;
            logic [6:0]  a;
            logic [15:0] d;
            rd = VEC[v][31]; a = VEC[v][30:24]; d = VEC[v][15:0];
            lat_cfg = int'(VEC[v][23:16]);
            e0 = en_count;
            bus_write(8'h70, ctl(1'b1, rd, a, d));
            bus_read(8'h74, r); chk(r[16] == 1, "R7 busy after start", r, 32'h1_0000);
            wait_idle(r);
            chk(r[16] == 0, "R7 busy clears", r, 0);
            chk(en_count == e0 + 1, "R4 one enable", en_count, e0 + 1);
            chk(rsp_addr == a, "R4 address", rsp_addr, a);
            chk(rsp_we == !rd, "R5 direction", rsp_we, !rd);
            if (!rd) chk(rsp_di == d, "R5 write data", rsp_di, d);
            if (rd) model_rd = d;
            chk(r[15:0] == model_rd, "R8 captured data", r[15:0], model_rd);
            bus_read(8'h70, r); chk(r == 0, "R11 control reads zero", r, 0);
        end

        // R6: start bit clear
        e0 = en_count;
        bus_write(8'h70, ctl(1'b0, 1'b0, 7'h05, 16'h5555));
        repeat (5) @(negedge clk);
        bus_read(8'h74, r);
        chk(en_count == e0 && r[16] == 0, "R6 no transaction", en_count, e0);

        // R9: write while busy
        lat_cfg = 20;
        e0 = en_count;
        bus_write(8'h70, ctl(1'b1, 1'b1, 7'h00, 16'h0));
        bus_write(8'h70, ctl(1'b1, 1'b0, 7'h7F, 16'h0000));
        wait_idle(r);
        chk(en_count == e0 + 1, "R9 busy write ignored", en_count, e0 + 1);
        lat_cfg = 2;
        bus_write(8'h70, ctl(1'b1, 1'b1, 7'h7F, 16'h0));
        wait_idle(r);
        chk(r[15:0] == 16'hA5A5, "R9 target untouched", r[15:0], 16'hA5A5);
        model_rd = 16'hA5A5;

        // R10: status read on the ready cycle
        lat_cfg = 4;
        bus_write(8'h70, ctl(1'b1, 1'b1, 7'h08, 16'h0));
        repeat (4) @(negedge clk);
        bus_read(8'h74, r);
        chk(r == {15'b0, 1'b1, model_rd}, "R10 pre-completion view", r, {15'b0, 1'b1, model_rd});
        bus_read(8'h74, r);
        chk(r == 32'h0000_1234, "R10 completed view", r, 32'h0000_1234);

        // R9: control write on the ready cycle
        lat_cfg = 3;
        e0 = en_count;
        bus_write(8'h70, ctl(1'b1, 1'b0, 7'h20, 16'h1111));
        repeat (3) @(negedge clk);
        bus_write(8'h70, ctl(1'b1, 1'b0, 7'h21, 16'h2222));
        repeat (4) @(negedge clk);
        bus_read(8'h74, r);
        chk(en_count == e0 + 1 && r[16] == 0, "R9 ready-cycle write ignored", en_count, e0 + 1);
        chk(drp_addr == 7'h20, "R9 address kept", drp_addr, 7'h20);
        lat_cfg = 1;
        bus_write(8'h70, ctl(1'b1, 1'b1, 7'h21, 16'h0));
        wait_idle(r);
        chk(r[15:0] == 16'h0000, "R9 ready-cycle target untouched", r[15:0], 0);
        chk(r[15:0] != 16'h2222, "R8 read replaces data", r[15:0], 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule